// File: doc/BRIEF.md
# Dual-Edge Biphase Line Encoder

This block serially encodes one data bit per clock period onto a single output line. It uses a biphase transition code. The line always changes level where a bit starts. It changes a second time, in the middle of the period, only when the bit is 0. A 1 therefore shows up as one long level across the period, and a 0 as two half-period levels.

The start of each bit is tied to the rising clock edge and the midpoint to the falling edge, so output events fall on a half-period grid. No doubled clock, dual-edge cell or gated clock is used. One register is clocked on the rising edge and one on the falling edge, and their exclusive-OR is the line. Each register's next value is the other register's value combined with the change the line must make, so either edge can flip the output.

The data bit and the enable are captured at the rising edge and held for the whole period, so the mid-bit decision always uses the bit whose period it is. With enable low, the line holds its level through both edges of that period. Framing, preambles and decoding belong to the surrounding logic.

Top module: `biphase_edge_enc`

## Requirements
- R1: An asynchronous active-high `rst` clears both edge registers at once, without waiting for a clock edge, so `line` reads 0 during reset and at the first edge after it.
- R2: In a period whose rising edge saw `en` = 1, `line` inverts at that rising edge (bit-start transition).
- R3: In an enabled period whose captured bit is 0, `line` inverts again at the falling edge (mid-bit transition).
- R4: In an enabled period whose captured bit is 1, `line` keeps its level at the falling edge.
- R5: `din` and `en` are sampled only at the rising edge. A change to `din` between a rising edge and the following falling edge does not alter the mid-bit decision of that period.
- R6: In a period whose rising edge saw `en` = 0, `line` keeps its level at both the rising and the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; the rising edge starts a bit, the falling edge marks its midpoint |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Encode enable, sampled at the rising edge |
| din | input | 1 | Data bit, sampled at the rising edge |
| line | output | 1 | Encoded line, XOR of the rising-edge and falling-edge registers |

## Verification
The assertions assume that `din` and `en` are settled at each rising edge and change at most once per clock period. They also assume that `rst` is held across at least one rising edge when it is asserted. The sweeps drive the inputs only in the low clock phase, just after a falling edge. The one deliberate breach is the R5 stimulus, which flips `din` in the high phase. The assertions stay valid under it because they judge the mid-bit change against the value captured at the rising edge.

// File: rtl/biphase_edge_enc.sv
module biphase_edge_enc (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic line
);

  logic rise_q;
  logic fall_q;
  logic bit_q;
  logic act_q;

  // each register flips the line by taking the other one XOR the wanted level
  logic rise_nxt;
  logic fall_nxt;

  assign rise_nxt = fall_q ^ ~line;
  assign fall_nxt = rise_q ^ ~line;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rise_q <= 1'b0;
      bit_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      bit_q <= din;
      act_q <= en;
      if (en) rise_q <= rise_nxt;
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst)                  fall_q <= 1'b0;
    else if (act_q && !bit_q) fall_q <= fall_nxt;
  end

  assign line = rise_q ^ fall_q;

endmodule

module biphase_edge_enc_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic din,
  input logic line
);

  logic pre_rise, en_r, d_r, seen_r;
  logic pre_fall, en_f, d_f, seen_f;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pre_rise <= 1'b0; en_r <= 1'b0; d_r <= 1'b0; seen_r <= 1'b0;
    end else begin
      pre_rise <= line; en_r <= en; d_r <= din; seen_r <= 1'b1;
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      pre_fall <= 1'b0; en_f <= 1'b0; d_f <= 1'b0; seen_f <= 1'b0;
    end else begin
      pre_fall <= line; en_f <= en_r; d_f <= d_r; seen_f <= seen_r;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |-> (line == 1'b0));

  a_r2_bit_start: assert property (@(negedge clk) disable iff (rst)
    (seen_r && en_r) |-> (line != pre_rise));

  // R5: the decision uses the bit held since the rising edge
  a_r3_zero_mid: assert property (@(posedge clk) disable iff (rst)
    (seen_f && en_f && !d_f) |-> (line != pre_fall));

  a_r4_one_flat: assert property (@(posedge clk) disable iff (rst)
    (seen_f && en_f && d_f) |-> (line == pre_fall));

  a_r6_hold_rise: assert property (@(negedge clk) disable iff (rst)
    (seen_r && !en_r) |-> (line == pre_rise));

  a_r6_hold_fall: assert property (@(posedge clk) disable iff (rst)
    (seen_f && !en_f) |-> (line == pre_fall));

endmodule

bind biphase_edge_enc biphase_edge_enc_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .line(line)
);

// File: tb/biphase_edge_enc_bench.sv
module biphase_edge_enc_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic din = 1'b0;
  logic line;

  int tests = 0;
  int fails = 0;
  logic exp_line = 1'b0;

  always #5 clk = ~clk;

  biphase_edge_enc u_biphase_edge_enc (
    .clk(clk), .rst(rst), .en(en), .din(din), .line(line)
  );

  task automatic check(input string req, input logic exp);
    tests++;
    if (line !== exp) begin
      fails++;
      $display("FAIL %s: line=%b expected=%b at %0t", req, line, exp, $time);
    end
  endtask

  // one bit period; inputs are driven in the low phase before the call
  task automatic bit_period(input logic e, input logic d, input logic glitch);
    en = e; din = d;
    @(posedge clk); #1;
    if (e) exp_line = ~exp_line;
    check(e ? "R2 bit start" : "R6 hold at rise", exp_line);
    if (glitch) din = ~d;
    @(negedge clk); #1;
    if (e && !d) exp_line = ~exp_line;
    if (!e)         check("R6 hold at mid", exp_line);
    else if (glitch) check("R5 captured bit", exp_line);
    else if (!d)     check("R3 zero mid flip", exp_line);
    else             check("R4 one no flip", exp_line);
    #1;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2; check("R1 reset low", 1'b0);
    @(posedge clk); #1; check("R1 reset at edge", 1'b0);
    @(negedge clk); #2; rst = 1'b0;

    for (int p = 0; p < 256; p++)
      for (int i = 0; i < 8; i++) bit_period(1'b1, p[i], 1'b0);

    for (int p = 0; p < 64; p++)
      for (int i = 0; i < 3; i++) bit_period(p[i+3], p[i], 1'b0);

    for (int i = 0; i < 8; i++) bit_period(1'b1, i[0], 1'b1);

    bit_period(1'b1, 1'b1, 1'b0);
    @(posedge clk); #2;
    rst = 1'b1; #1;
    exp_line = 1'b0;
    check("R1 async clear", 1'b0);
    @(negedge clk); #1; check("R1 held in reset", 1'b0);
    @(posedge clk); #1; check("R1 held in reset", 1'b0);
    @(negedge clk); #2; rst = 1'b0;

    for (int i = 0; i < 16; i++) bit_period(1'b1, i[1] ^ i[0], 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule